// File: doc/BRIEF.md
# Modulo Data-Memory Address Generator

This block turns a logical data-memory offset into a physical word address for a data memory of 6144 words, built as twelve pages of 512 words. A size register selects how many pages form a circular region at the bottom of the memory. The pages above that region form a directly addressed, non-circular area. A base pointer moves down by one word at every end-of-program strobe. Circular accesses add the offset to this pointer and wrap inside the region. Delay lines and filter histories therefore age by one sample per program pass, and no stored data is ever moved.

Every instruction presents an offset and a region select. The region select picks either the circular region or the non-circular area above it. Non-circular accesses ignore the pointer and are placed directly above the circular region. The physical address is registered. The memory array and the instruction decoder are outside this block.

Top module: `modulo_ram_agu`

## Requirements
- R1: Synchronous active-low reset sets `phys_addr` to 0, the size register to 12 pages and the base pointer to 0. After reset a circular access with offset o therefore yields o mod 6144.
- R2: A cycle with `size_wr`=1 loads `size_cfg` into the size register. The region length is then size × 512 words, so a non-circular access with offset 0 returns the region length.
- R3: A `size_cfg` value above 12 is stored as 12.
- R4: A size write resets the base pointer to 0.
- R5: Each `frame_end` pulse that coincides with no size write decrements the base pointer by one. Decrementing from 0 wraps it to region length − 1.
- R6: With `linear_sel`=0 and a nonzero size, the address is (base + offset) mod (size × 512) for every offset from 0 to 8191. The result always lies below the region length.
- R7: With `linear_sel`=1, the address is the low 13 bits of (size × 512 + offset). The base pointer has no effect on it.
- R8: When the size is 0, every access returns the offset unchanged, and `frame_end` leaves the base pointer at 0.
- R9: `phys_addr` shows the result for the inputs sampled at a clock edge from that edge until the next one. The result uses the base pointer and size held before that edge, even when a `frame_end` or size write is sampled at the same edge.
- R10: While neither `frame_end` nor `size_wr` is asserted, the base pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| size_wr | input | 1 | Load `size_cfg` into the size register |
| size_cfg | input | 4 | New circular-region size in 512-word pages |
| frame_end | input | 1 | End-of-program strobe; steps the base pointer |
| offset | input | 13 | Logical offset supplied by the instruction |
| linear_sel | input | 1 | 1 selects the non-circular area, 0 the circular region |
| phys_addr | output | 13 | Registered physical word address |

## Verification
Every address is due exactly one clock edge after its offset, region select and strobes are presented. The bench drives inputs on the falling edge and checks `phys_addr` on the following falling edge. A reference model of the size register and base pointer gives the expected address from the values held before that edge, and is then advanced for any `frame_end` or size write in the same cycle. A size write or strobe therefore changes only the next access, and the checks use that order.

// File: rtl/agu_pkg.sv
// Package: shared types for the modulo address generator.
// Assumes: nothing beyond IEEE 1800-2017.
package agu_pkg;

    // Which region an access targets.
    typedef enum logic {
        ACC_CIRC   = 1'b0,
        ACC_LINEAR = 1'b1
    } acc_mode_e;

    // Reset page count default: the whole memory is circular.
    localparam int unsigned DEFAULT_PAGES = 12;

endpackage : agu_pkg

// File: rtl/agu_size_reg.sv
// Module: agu_size_reg
// Holds the circular-region size in pages. It loads on a write strobe and
// clamps values above NUM_PAGES to NUM_PAGES. Reset sets it to NUM_PAGES.
// Assumes: NUM_PAGES fits in SIZE_W bits.
module agu_size_reg #(
    parameter int unsigned NUM_PAGES = 12,
    parameter int unsigned SIZE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              size_wr,
    input  logic [SIZE_W-1:0] size_cfg,
    output logic [SIZE_W-1:0] size_q
);

    localparam logic [SIZE_W-1:0] FULL = SIZE_W'(NUM_PAGES);

    logic [SIZE_W-1:0] cfg_clamped;

    // Limit the requested size to the number of pages present.
    always_comb begin
        cfg_clamped = (size_cfg > FULL) ? FULL : size_cfg;
    end

    // Size register: full memory after reset, new value on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= FULL;
        end else if (size_wr) begin
            size_q <= cfg_clamped;
        end
    end

    assert_size_clamped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        size_q <= FULL);

    assert_size_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (size_wr && size_cfg <= FULL) |=> size_q == $past(size_cfg));

    assert_size_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !size_wr |=> $stable(size_q));

endmodule : agu_size_reg

// File: rtl/agu_base_ptr.sv
// Module: agu_base_ptr
// The base pointer of the circular region. Each step strobe moves it down
// by one word, wrapping from 0 to region_len-1. A clear strobe (a size
// change) returns it to 0. It stays at 0 while the region is empty.
// Assumes: region_len changes only in a cycle where clear is asserted.
module agu_base_ptr #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned LEN_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              clear,
    input  logic [LEN_W-1:0]  region_len,
    output logic [ADDR_W-1:0] base
);

    logic [LEN_W-1:0] len_m1;

    // Last word of the region, the wrap target of a decrement.
    always_comb begin
        len_m1 = region_len - LEN_W'(1);
    end

    // Pointer update: clear has priority, then a wrapping decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
        end else if (clear) begin
            base <= '0;
        end else if (step && region_len != '0) begin
            base <= (base == '0) ? ADDR_W'(len_m1) : base - ADDR_W'(1);
        end
    end

    assert_base_in_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (region_len != '0) |-> (LEN_W'(base) < region_len));

    assert_base_empty_region_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (region_len == '0) |-> (base == '0));

    assert_base_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (base == '0));

    assert_base_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(base));

endmodule : agu_base_ptr

// File: rtl/agu_page_mod.sv
// Module: agu_page_mod
// Combinational remainder of a small page number by the region size in
// pages. It is a restoring divider unrolled into QB compare/subtract
// stages, one stage per bit of the page number.
// Assumes: divisor != 0 whenever rem is used. With divisor 0 the caller
// discards rem.
module agu_page_mod #(
    parameter int unsigned QB     = 5,
    parameter int unsigned SIZE_W = 4
) (
    input  logic [QB-1:0]     page_in,
    input  logic [SIZE_W-1:0] divisor,
    output logic [SIZE_W-1:0] rem
);

    localparam int unsigned W = QB + SIZE_W;

    logic [W-1:0] stage_val [QB+1];

    assign stage_val[0] = W'(page_in);

    // One stage per quotient bit, highest weight first.
    for (genvar k = 0; k < QB; k++) begin : g_stage
        localparam int unsigned SH = QB - 1 - k;
        logic [W-1:0] trial;
        assign trial = W'(divisor) << SH;
        assign stage_val[k+1] = (stage_val[k] >= trial) ? stage_val[k] - trial
                                                        : stage_val[k];
    end

    assign rem = SIZE_W'(stage_val[QB]);

    // The final remainder must lie below the divisor.
    always_comb begin
        if (divisor != '0) begin
            assert_rem_below_size_R6: assert (stage_val[QB] < W'(divisor));
        end
    end

endmodule : agu_page_mod

// File: rtl/modulo_ram_agu.sv
// Module: modulo_ram_agu (top)
// Registered physical address generator for a paged data memory. The lower
// region of the memory is circular; the pages above it are addressed
// directly.
// Assumes: the page size is a power of two. Offsets cover OFFSET_W bits.
// The size register is the only configuration.
module modulo_ram_agu
    import agu_pkg::*;
#(
    parameter  int unsigned PAGE_WORDS = 512,
    parameter  int unsigned NUM_PAGES  = DEFAULT_PAGES,
    parameter  int unsigned OFFSET_W   = 13,
    localparam int unsigned PAGE_BITS  = $clog2(PAGE_WORDS),
    localparam int unsigned MEM_WORDS  = PAGE_WORDS * NUM_PAGES,
    localparam int unsigned ADDR_W     = $clog2(MEM_WORDS),
    localparam int unsigned SIZE_W     = $clog2(NUM_PAGES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                size_wr,
    input  logic [SIZE_W-1:0]   size_cfg,
    input  logic                frame_end,
    input  logic [OFFSET_W-1:0] offset,
    input  logic                linear_sel,
    output logic [ADDR_W-1:0]   phys_addr
);

    localparam int unsigned LEN_W = ADDR_W + 1;
    localparam int unsigned SUM_W = ((ADDR_W > OFFSET_W) ? ADDR_W : OFFSET_W) + 1;
    localparam int unsigned QB    = SUM_W - PAGE_BITS;

    logic [SIZE_W-1:0] size_q;
    logic [LEN_W-1:0]  region_len;
    logic [ADDR_W-1:0] base;
    logic [SUM_W-1:0]  circ_sum;
    logic [SIZE_W-1:0] page_rem;
    logic [ADDR_W-1:0] circ_addr;
    logic [ADDR_W-1:0] lin_addr;
    logic [ADDR_W-1:0] next_addr;
    acc_mode_e         mode;

    agu_size_reg #(
        .NUM_PAGES (NUM_PAGES),
        .SIZE_W    (SIZE_W)
    ) size_reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .size_wr  (size_wr),
        .size_cfg (size_cfg),
        .size_q   (size_q)
    );

    // Region length in words: pages times the page size.
    always_comb begin
        region_len = LEN_W'({size_q, {PAGE_BITS{1'b0}}});
    end

    agu_base_ptr #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) base_ptr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (frame_end),
        .clear      (size_wr),
        .region_len (region_len),
        .base       (base)
    );

    // Unwrapped circular sum; the page field goes to the reducer.
    always_comb begin
        circ_sum = SUM_W'(base) + SUM_W'(offset);
    end

    agu_page_mod #(
        .QB     (QB),
        .SIZE_W (SIZE_W)
    ) page_mod_i (
        .page_in (circ_sum[SUM_W-1:PAGE_BITS]),
        .divisor (size_q),
        .rem     (page_rem)
    );

    // Address candidates for both regions and the selection between them.
    always_comb begin
        circ_addr = ADDR_W'({page_rem, circ_sum[PAGE_BITS-1:0]});
        lin_addr  = ADDR_W'(region_len + LEN_W'(offset));
        mode      = linear_sel ? ACC_LINEAR : ACC_CIRC;
        if (mode == ACC_LINEAR || size_q == '0) begin
            next_addr = lin_addr;
        end else begin
            next_addr = circ_addr;
        end
    end

    // Output register: one clock of latency from the inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_addr <= '0;
        end else begin
            phys_addr <= next_addr;
        end
    end

    assert_circ_in_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!linear_sel && region_len != '0) |=> (LEN_W'(phys_addr) < $past(region_len)));

    assert_linear_above_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (linear_sel && offset == '0) |=> (LEN_W'(phys_addr) == $past(region_len)));

endmodule : modulo_ram_agu

// File: tb/modulo_ram_agu_tb.sv
// Bench: sweeps every size code, a spread of offsets in both regions, and
// full wraps of the base pointer. Expected addresses come from an
// arithmetic model.
module modulo_ram_agu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        size_wr = 1'b0;
    logic [3:0]  size_cfg = '0;
    logic        frame_end = 1'b0;
    logic [12:0] offset = '0;
    logic        linear_sel = 1'b0;
    logic [12:0] phys_addr;

    int checks = 0;
    int errors = 0;
    int size_m = 12;
    int base_m = 0;

    always #10 clk = ~clk;

    modulo_ram_agu dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .size_wr    (size_wr),
        .size_cfg   (size_cfg),
        .frame_end  (frame_end),
        .offset     (offset),
        .linear_sel (linear_sel),
        .phys_addr  (phys_addr)
    );

    task automatic check(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // Drive one access at a falling edge; check it at the next falling edge.
    task automatic step(input bit wr, input int cfg, input bit fe,
                        input bit lin, input int off, input string tag);
        int len;
        int exp;
        size_wr    = wr;
        size_cfg   = 4'(cfg);
        frame_end  = fe;
        linear_sel = lin;
        offset     = 13'(off);
        len = size_m * 512;
        if (lin || len == 0) exp = (len + off) % 8192;
        else                 exp = (base_m + off) % len;
        if (wr) begin
            size_m = (cfg > 12) ? 12 : cfg;
            base_m = 0;
        end else if (fe && len != 0) begin
            base_m = (base_m == 0) ? len - 1 : base_m - 1;
        end
        @(negedge clk);
        check(int'(phys_addr), exp, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        string ct;
        repeat (3) @(negedge clk);
        check(int'(phys_addr), 0, "R1");
        rst_n = 1'b1;
        step(0, 0, 0, 0, 6149, "R1");
        step(0, 0, 1, 0, 10, "R9");
        step(0, 0, 0, 0, 10, "R5");
        step(0, 0, 0, 1, 100, "R7");
        repeat (8) step(0, 0, 0, 0, 300, "R10");
        for (int cfg = 0; cfg < 16; cfg++) begin
            step(1, cfg, 0, 0, 77, "R9");
            ct = (cfg == 0) ? "R8" : ((cfg > 12) ? "R3" : "R6");
            step(0, 0, 0, 0, 0, "R4");
            step(0, 0, 0, 1, 0, (cfg > 12) ? "R3" : "R2");
            for (int off = 0; off < 8192; off += 97) begin
                step(0, 0, (off % 3) == 0, (off % 5) == 0, off,
                     ((off % 5) == 0) ? "R7" : ct);
            end
            for (int i = 0; i < size_m * 512 + 5; i++) begin
                step(0, 0, 1, 0, 511, (cfg == 0) ? "R8" : "R5");
            end
            repeat (4) step(0, 0, 0, 0, 1000, "R10");
        end
        size_wr   = 1'b0;
        frame_end = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule : modulo_ram_agu_tb_top